// File: doc/BRIEF.md
# Paged Flash Buffer Command Decoder

This block is the device-side receive front end of a paged serial flash with two page buffers. While chip select is low it takes in a 32-bit command on the serial input, sampled on rising serial-clock edges with the most significant bit first. The first byte selects one of three buffer operations: load a main-memory page into a buffer, compare a page with a buffer, or rewrite a page through a buffer. The second bit of information, which buffer, also comes from that byte. The remaining 24 bits carry a 12-bit page number, and the `page_mode` input sets where it sits.

Nothing starts when the last bit arrives. The operation is launched only when chip select returns high, and only if exactly 32 or more bits were seen and the opcode is one of the six known codes. The block then drives a request/acknowledge port toward the memory array. A rewrite becomes two requests in a row: a load into the buffer, then a program of the buffer back into the same page. A status byte reports ready/busy and the outcome of the most recent compare.

The serial pins are brought into the system clock domain through two-stage synchronisers. The serial clock must therefore run well below the system clock.

Top module: `sflash_bufcmd_decoder`

## Requirements
- R1: Opcode 0x53 issues one request with `mem_op`=2'b00 (load page into buffer) and `mem_buf`=0. Opcode 0x55 issues the same request with `mem_buf`=1.
- R2: Opcode 0x60 issues one request with `mem_op`=2'b01 (compare page with buffer) and `mem_buf`=0. Opcode 0x61 issues the same request with `mem_buf`=1.
- R3: Opcodes 0x58 (`mem_buf`=0) and 0x59 (`mem_buf`=1) issue two requests for the same page and buffer. The first has `mem_op`=2'b00. After its acknowledge, the second has `mem_op`=2'b10 (program page from buffer). The block stays busy until the second acknowledge.
- R4: With `page_mode`=0 (264-byte pages), `mem_page` is address bits 20..9 of the 24 address bits. Those are the bits that follow 3 ignored bits. The low 9 bits are ignored.
- R5: With `page_mode`=1 (256-byte pages), `mem_page` is address bits 19..8. Those are the bits that follow 4 ignored bits. The low 8 bits are ignored.
- R6: No request is raised while chip select stays low, even after all 32 bits have arrived. The operation starts only after chip select rises.
- R7: A command is discarded, and no request follows, in two cases: chip select rises after fewer than 32 bits, or the opcode is not one of the six listed. Bits beyond the 32nd are ignored.
- R8: Status bit 7 is 1 when ready and 0 while an operation is in progress. Bit 6 is the compare result: 0 for match, 1 for differ. Bit 6 is taken from `mem_mismatch` only on the acknowledge of a compare request and is left unchanged by any other operation. Bits 5..0 are 0. After reset the status reads 0x80.
- R9: Once raised, `mem_req` stays high, with `mem_op`, `mem_buf` and `mem_page` stable, until the cycle in which `mem_ack` is high.
- R10: A command completed while an operation is in progress is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock, data sampled on its rising edge |
| spi_si | input | 1 | Serial data in, MSB first |
| page_mode | input | 1 | 0: 264-byte page layout, 1: 256-byte page layout |
| mem_req | output | 1 | Request to the memory array |
| mem_op | output | 2 | 00 load page into buffer, 01 compare, 10 program page from buffer |
| mem_buf | output | 1 | Buffer select (0 or 1) |
| mem_page | output | 12 | Page number |
| mem_ack | input | 1 | One-cycle acknowledge that the request has finished |
| mem_mismatch | input | 1 | Compare result, valid with `mem_ack` |
| status | output | 8 | Bit 7 ready, bit 6 compare differs, others 0 |

## Verification
The bench fills the ignored address bits with ones and alternating patterns. A decoder that used the wrong page layout for the selected mode would therefore report a wrong page, not a lucky match. It holds chip select low well after the 32nd bit, to catch a design that launches on the last bit. It also sends a 31-bit command, a 40-bit command and an unknown opcode; a design that launches on these would raise a request. It sends a command while an operation is still unacknowledged, to catch a design that queues or corrupts that command. It runs loads and rewrites with the mismatch input high after a compare, so a design that lets any acknowledge update the compare flag would report a wrong bit 6.

// File: rtl/sflash_bufcmd_decoder.sv
module sflash_bufcmd_decoder #(
  parameter int CMD_BITS = 32,
  parameter int PAGE_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_si,
  input  logic              page_mode,
  output logic              mem_req,
  output logic [1:0]        mem_op,
  output logic              mem_buf,
  output logic [PAGE_W-1:0] mem_page,
  input  logic              mem_ack,
  input  logic              mem_mismatch,
  output logic [7:0]        status
);
  localparam int CNT_W   = $clog2(CMD_BITS + 1);
  localparam int STD_LSB = 9;
  localparam int BIN_LSB = 8;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CMD_BITS);
  localparam logic [1:0] OP_LOAD = 2'b00, OP_CMP = 2'b01, OP_PROG = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_PROG} st_t;
  typedef enum logic [1:0] {K_LOAD, K_CMP, K_RW} kind_t;

  logic [2:0] cs_s, sck_s;
  logic [1:0] si_s;
  logic [CMD_BITS-1:0] sh;
  logic [CNT_W-1:0] cnt;
  st_t state;
  kind_t kind, dec_kind;
  logic dec_ok, dec_buf, cmp_diff, cs_rise, sck_rise, launch;
  logic [7:0] opcode;
  logic [PAGE_W-1:0] dec_page;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_s <= 3'b111; sck_s <= '0; si_s <= '0;
    end else begin
      cs_s <= {cs_s[1:0], spi_cs_n};
      sck_s <= {sck_s[1:0], spi_sck};
      si_s <= {si_s[0], spi_si};
    end

  assign cs_rise  = cs_s[1] & ~cs_s[2];
  assign sck_rise = sck_s[1] & ~sck_s[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh <= '0; cnt <= '0;
    end else if (cs_s[1]) begin
      cnt <= '0;
    end else if (sck_rise && cnt != FULL) begin
      sh  <= {sh[CMD_BITS-2:0], si_s[1]};
      cnt <= cnt + 1'b1;
    end

  assign opcode   = sh[CMD_BITS-1 -: 8];
  assign dec_page = page_mode ? sh[BIN_LSB +: PAGE_W] : sh[STD_LSB +: PAGE_W];

  always_comb begin
    dec_ok = 1'b1; dec_buf = 1'b0; dec_kind = K_LOAD;
    case (opcode)
      8'h53: begin dec_kind = K_LOAD; dec_buf = 1'b0; end
      8'h55: begin dec_kind = K_LOAD; dec_buf = 1'b1; end
      8'h60: begin dec_kind = K_CMP;  dec_buf = 1'b0; end
      8'h61: begin dec_kind = K_CMP;  dec_buf = 1'b1; end
      8'h58: begin dec_kind = K_RW;   dec_buf = 1'b0; end
      8'h59: begin dec_kind = K_RW;   dec_buf = 1'b1; end
      default: dec_ok = 1'b0;
    endcase
  end

  assign launch = cs_rise && cnt == FULL && dec_ok && state == S_IDLE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; kind <= K_LOAD; mem_buf <= 1'b0; mem_page <= '0; cmp_diff <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (launch) begin
          state <= S_FETCH; kind <= dec_kind; mem_buf <= dec_buf; mem_page <= dec_page;
        end
        S_FETCH: if (mem_ack) begin
          if (kind == K_CMP) cmp_diff <= mem_mismatch;
          state <= (kind == K_RW) ? S_PROG : S_IDLE;
        end
        S_PROG: if (mem_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end

  assign mem_req = state != S_IDLE;
  assign mem_op  = (state == S_PROG) ? OP_PROG : (kind == K_CMP ? OP_CMP : OP_LOAD);
  assign status  = {state == S_IDLE, cmp_diff, 6'b0};

  a_r6_start_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(cs_rise));
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_op) && $stable(mem_buf) && $stable(mem_page));
  a_r3_prog_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack && mem_op == OP_LOAD && kind == K_RW |=> mem_req && mem_op == OP_PROG && $stable(mem_page));
  a_r3_prog_ends: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack && mem_op == OP_PROG |=> !mem_req && status[7]);
  a_r8_flag_only_on_compare: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_ack && mem_op == OP_CMP) |=> $stable(status[6]));
  a_r10_busy_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(mem_page));
endmodule

// File: tb/sflash_bufcmd_decoder_test.sv
module sflash_bufcmd_decoder_test;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, pmode = 0, ack = 0, mism = 0;
  logic req, mbuf;
  logic [1:0] mop;
  logic [11:0] mpage;
  logic [7:0] st;
  int checks = 0, fails = 0;
  logic exp_flag = 0;

  always #4 clk = ~clk;

  sflash_bufcmd_decoder uut (.clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
    .page_mode(pmode), .mem_req(req), .mem_op(mop), .mem_buf(mbuf), .mem_page(mpage),
    .mem_ack(ack), .mem_mismatch(mism), .status(st));

  localparam int NV = 8;
  localparam logic [7:0]  V_OPC  [NV] = '{8'h53, 8'h55, 8'h60, 8'h53, 8'h61, 8'h58, 8'h59, 8'h55};
  localparam logic        V_MODE [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [11:0] V_PAGE [NV] = '{12'hABC, 12'h123, 12'hFFF, 12'h001, 12'h800, 12'h5A5, 12'h000, 12'h7E1};
  localparam logic        V_MISM [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [1:0]  V_EOP  [NV] = '{2'b00, 2'b00, 2'b01, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00};
  localparam logic        V_EBUF [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic        V_RW   [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp); end
  endtask

  function automatic logic [31:0] mkword(input logic [7:0] opc, input logic md, input logic [11:0] pg);
    return md ? {opc, 4'hF, pg, 8'hA5} : {opc, 3'b111, pg, 9'h155};
  endfunction

  task automatic shift_bits(input logic [39:0] w, input int n);
    @(negedge clk); cs_n = 0; repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      si = w[39 - i]; repeat (4) @(negedge clk);
      sck = 1; repeat (4) @(negedge clk);
      sck = 0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic raise_cs;
    cs_n = 1; repeat (2) @(negedge clk);
  endtask

  task automatic expect_req(input logic [1:0] op, input logic b, input logic [11:0] pg,
                            input logic m, input bit do_ack, input string rq);
    int n = 0;
    while (!req && n < 200) begin @(negedge clk); n++; end
    chk(req === 1'b1, rq, req, 1);
    chk(mop === op, rq, mop, op);
    chk(mbuf === b, rq, mbuf, b);
    chk(mpage === pg, rq, mpage, pg);
    chk(st[7] === 1'b0, "R8 busy", st[7], 0);
    repeat (3) @(negedge clk);
    chk(req === 1'b1 && mop === op && mpage === pg, "R9 hold", {req, mop, mpage}, {1'b1, op, pg});
    if (do_ack) begin
      ack = 1; mism = m; @(negedge clk); ack = 0; mism = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(st === 8'h80 && req === 1'b0, "R8 reset", st, 8'h80);
    rst_n = 1; repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      pmode = V_MODE[v];
      shift_bits({mkword(V_OPC[v], V_MODE[v], V_PAGE[v]), 8'h00}, 32);
      repeat (10) @(negedge clk);
      chk(req === 1'b0, "R6 no start before cs rise", req, 0);
      raise_cs;
      expect_req(V_EOP[v], V_EBUF[v], V_PAGE[v], V_MISM[v], 1'b1,
                 V_RW[v] ? "R3 rewrite load" : (V_EOP[v] == 2'b01 ? "R2 compare" :
                 (V_MODE[v] ? "R1 R5 load" : "R1 R4 load")));
      if (V_RW[v]) begin
        chk(req === 1'b1 && st[7] === 1'b0, "R3 still busy", st[7], 0);
        expect_req(2'b10, V_EBUF[v], V_PAGE[v], 1'b1, 1'b1, "R3 rewrite program");
      end
      if (V_EOP[v] == 2'b01) exp_flag = V_MISM[v];
      repeat (2) @(negedge clk);
      chk(req === 1'b0, "R3 done", req, 0);
      chk(st === {1'b1, exp_flag, 6'b0}, "R8 status", st, {1'b1, exp_flag, 6'b0});
    end

    pmode = 0;
    shift_bits({mkword(8'h53, 1'b0, 12'h321), 8'h00}, 31);
    raise_cs; repeat (40) @(negedge clk);
    chk(req === 1'b0, "R7 short command", req, 0);

    shift_bits({mkword(8'h54, 1'b0, 12'h321), 8'h00}, 32);
    raise_cs; repeat (40) @(negedge clk);
    chk(req === 1'b0 && st[7] === 1'b1, "R7 unknown opcode", {req, st[7]}, 2'b01);

    shift_bits({mkword(8'h60, 1'b0, 12'h9C3), 8'hFF}, 40);
    raise_cs;
    expect_req(2'b01, 1'b0, 12'h9C3, 1'b0, 1'b1, "R7 extra bits ignored");
    exp_flag = 0;

    shift_bits({mkword(8'h53, 1'b0, 12'h111), 8'h00}, 32);
    raise_cs;
    expect_req(2'b00, 1'b0, 12'h111, 1'b0, 1'b0, "R10 first");
    shift_bits({mkword(8'h55, 1'b0, 12'h222), 8'h00}, 32);
    raise_cs; repeat (5) @(negedge clk);
    chk(mpage === 12'h111 && mbuf === 1'b0, "R10 busy command ignored", mpage, 12'h111);
    ack = 1; @(negedge clk); ack = 0;
    repeat (40) @(negedge clk);
    chk(req === 1'b0 && st === 8'h80, "R10 nothing queued", {req, st}, {1'b0, 8'h80});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule